// File: doc/BRIEF.md
# Preset-range modulo counter

A 4-bit synchronous counter that repeats a contiguous run of values from a start value to an end value. Every bit is clocked by one shared clock. The next value comes from an AND/XOR incrementer, so no bit waits on another bit's flip-flop.

A comparator watches the count for the end value. When it finds it, it steers the parallel-load path so that the start value is loaded again. An external load port uses that same path and can place any value in the counter.

A carry flag is high while the counter is enabled and sitting at the end value. It can drive the enable of a following stage to build a longer cascade. The start and end values are elaboration-time parameters. The usual settings are 0..6 (seven states), 0..9 (decimal digit) and 9..14 (six states starting at nine). Reset loads the start value, not zero.

Top module: `preset_range_counter`

## Requirements
- R1: When rst_ni is low at a rising clock edge, count_o becomes START_VAL after that edge, whatever the other inputs are.
- R2: When rst_ni is high and load_i is high at an edge, count_o becomes load_data_i after that edge. This holds whatever cnt_en_i is and whatever the present count is, including END_VAL.
- R3: When rst_ni is high, load_i is low, cnt_en_i is high and count_o is not END_VAL, count_o becomes count_o + 1 after the edge.
- R4: When rst_ni is high, load_i is low, cnt_en_i is high and count_o equals END_VAL, count_o becomes START_VAL after the edge.
- R5: When rst_ni is high and both load_i and cnt_en_i are low, count_o keeps its value. This includes a counter held at END_VAL, which does not reload.
- R6: carry_o is a combinational output. It is 1 exactly when cnt_en_i is 1 and count_o equals END_VAL.
- R7: A value above END_VAL placed by an external load keeps incrementing while enabled. From 15 it wraps to 0, and it then runs on to END_VAL. carry_o stays 0 through all of these values.
- R8: The three settings give these sequences under a constant enable: START_VAL=0, END_VAL=6 gives 0..6; START_VAL=0, END_VAL=9 gives 0..9; START_VAL=9, END_VAL=14 gives 9..14. Each sequence repeats without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Synchronous reset, active low, loads START_VAL |
| cnt_en_i | input | 1 | Count enable |
| load_i | input | 1 | External parallel load request |
| load_data_i | input | 4 | Value captured by an external load |
| count_o | output | 4 | Present count |
| carry_o | output | 1 | High while enabled at END_VAL |

## Verification
Some behaviours are checked on every cycle by the assertions. These are the arithmetic of the incrementer chain, the reset preset, the priority of the external load, the reload at the end value, holding while disabled, and the rule that carry only appears at the end value.

Other behaviours only show up over many cycles, and only the bench's scenarios can demonstrate them. These are the full repeating sequence of each parameter set, the walk of an out-of-range loaded value through 15 and 0 back into range, and that the three settings behave the same way under identical stimulus. The bench sweeps all sixteen load values on all three settings and compares every cycle against an arithmetic model.

// File: rtl/prc_pkg.sv
package prc_pkg;
  typedef enum logic [2:0] {
    SEL_HOLD,
    SEL_INC,
    SEL_WRAP,
    SEL_LOAD,
    SEL_RST
  } prc_sel_e;
endpackage

// File: rtl/prc_incr.sv
module prc_incr #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             en_i,
  input  logic [WIDTH-1:0] val_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH:0] chain;

  assign chain[0] = en_i;
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    // toggle bit i when every lower bit is 1
    assign sum_o[i]    = val_i[i] ^ chain[i];
    assign chain[i+1]  = chain[i] & val_i[i];
  end
  assign cout_o = chain[WIDTH];

  // R3
  always_ff @(posedge clk_i) begin
    if (en_i) begin
      incr_sum_chk: assert (sum_o == WIDTH'(val_i + 1'b1))
        else $error("incrementer sum wrong");
    end
  end
endmodule

// File: rtl/prc_term.sv
module prc_term #(
  parameter int WIDTH   = 4,
  parameter int END_VAL = 6
) (
  input  logic [WIDTH-1:0] val_i,
  output logic             hit_o
);
  localparam logic [WIDTH-1:0] EndBits = WIDTH'(END_VAL);
  logic [WIDTH-1:0] eq;

  // full compare: loaded values above the end value must not alias onto it
  for (genvar i = 0; i < WIDTH; i++) begin : g_eq
    assign eq[i] = ~(val_i[i] ^ EndBits[i]);
  end
  assign hit_o = &eq;
endmodule

// File: rtl/prc_sel.sv
module prc_sel
  import prc_pkg::*;
(
  input  logic     rst_ni,
  input  logic     load_i,
  input  logic     en_i,
  input  logic     term_i,
  output prc_sel_e sel_o
);
  always_comb begin
    if (!rst_ni)           sel_o = SEL_RST;
    else if (load_i)       sel_o = SEL_LOAD;
    else if (en_i && term_i) sel_o = SEL_WRAP;
    else if (en_i)         sel_o = SEL_INC;
    else                   sel_o = SEL_HOLD;
  end
endmodule

// File: rtl/preset_range_counter.sv
module preset_range_counter
  import prc_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter int START_VAL = 0,
  parameter int END_VAL   = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_data_i,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_o
);
  localparam logic [WIDTH-1:0] StartBits = WIDTH'(START_VAL);
  localparam logic [WIDTH-1:0] EndBits   = WIDTH'(END_VAL);

  logic [WIDTH-1:0] count_q, count_d, inc_sum;
  logic             inc_cout, term_hit;
  prc_sel_e         sel;
  logic             seen_q;

  prc_incr #(.WIDTH(WIDTH)) u_incr (
    .clk_i  (clk_i),
    .en_i   (cnt_en_i),
    .val_i  (count_q),
    .sum_o  (inc_sum),
    .cout_o (inc_cout)
  );

  prc_term #(.WIDTH(WIDTH), .END_VAL(END_VAL)) u_term (
    .val_i (count_q),
    .hit_o (term_hit)
  );

  prc_sel u_sel (
    .rst_ni (rst_ni),
    .load_i (load_i),
    .en_i   (cnt_en_i),
    .term_i (term_hit),
    .sel_o  (sel)
  );

  // reload path shared by reset, external load and terminal count
  always_comb begin
    unique case (sel)
      SEL_RST:  count_d = StartBits;
      SEL_LOAD: count_d = load_data_i;
      SEL_WRAP: count_d = StartBits;
      SEL_INC:  count_d = inc_sum;
      default:  count_d = count_q;
    endcase
  end

  always_ff @(posedge clk_i) begin
    count_q <= count_d;
    seen_q  <= 1'b1;
  end

  assign count_o = count_q;
  // carry is only meaningful at the end value; full chain carry is unused below 15
  assign carry_o = term_hit & cnt_en_i;

  // R1
  reset_preset_chk: assert property (@(posedge clk_i) disable iff (!seen_q)
    !rst_ni |=> count_o == StartBits);
  // R2
  load_prio_chk: assert property (@(posedge clk_i) disable iff (!seen_q)
    (rst_ni && load_i) |=> count_o == $past(load_data_i));
  // R4
  term_reload_chk: assert property (@(posedge clk_i) disable iff (!seen_q)
    (rst_ni && !load_i && cnt_en_i && count_o == EndBits) |=> count_o == StartBits);
  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!seen_q)
    (rst_ni && !load_i && !cnt_en_i) |=> $stable(count_o));
  // R6
  carry_end_chk: assert property (@(posedge clk_i) disable iff (!seen_q)
    carry_o |-> (cnt_en_i && count_o == EndBits));
  // R7
  wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!seen_q)
    (rst_ni && !load_i && cnt_en_i && inc_cout && !term_hit) |=> count_o == '0);
endmodule

// File: tb/preset_range_counter_test.sv
`timescale 1ns/1ps
module preset_range_counter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       ld = 1'b0;
  logic [3:0] din = 4'd0;
  logic [3:0] q_a, q_b, q_c;
  logic       c_a, c_b, c_c;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  preset_range_counter #(.START_VAL(0), .END_VAL(6)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(en), .load_i(ld),
    .load_data_i(din), .count_o(q_a), .carry_o(c_a));
  preset_range_counter #(.START_VAL(0), .END_VAL(9)) uut_bcd (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(en), .load_i(ld),
    .load_data_i(din), .count_o(q_b), .carry_o(c_b));
  preset_range_counter #(.START_VAL(9), .END_VAL(14)) uut_off (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(en), .load_i(ld),
    .load_data_i(din), .count_o(q_c), .carry_o(c_c));

  logic [3:0] m_a, m_b, m_c;
  string      tag;

  function automatic logic [3:0] nxt(input logic [3:0] q, input int s, input int e,
                                     output string t);
    if (!rst_n)                 begin t = "R1"; return 4'(s); end
    if (ld)                     begin t = "R2"; return din; end
    if (en && int'(q) == e)     begin t = "R4"; return 4'(s); end
    if (en && int'(q) > e)      begin t = "R7"; return 4'(q + 1); end
    if (en)                     begin t = "R3"; return 4'(q + 1); end
    t = "R5"; return q;
  endfunction

  task automatic chk(input string t, input string nm, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", t, nm, act, exp);
    end
  endtask

  // drive after negedge, clock it, check after the posedge; carry checked before the edge
  task automatic step(input logic r, input logic l, input logic e, input logic [3:0] d);
    string ta, tb_, tc;
    @(negedge clk);
    rst_n = r; ld = l; en = e; din = d;
    #0.5;
    chk("R6", "carry mod7", c_a, int'(e && q_a == 4'd6));
    chk("R6", "carry bcd",  c_b, int'(e && q_b == 4'd9));
    chk("R6", "carry off",  c_c, int'(e && q_c == 4'd14));
    m_a = nxt(q_a, 0, 6, ta);
    m_b = nxt(q_b, 0, 9, tb_);
    m_c = nxt(q_c, 9, 14, tc);
    @(posedge clk); #1;
    chk(ta,  "count mod7", q_a, m_a);
    chk(tb_, "count bcd",  q_b, m_b);
    chk(tc,  "count off",  q_c, m_c);
  endtask

  initial begin
    // R1 reset with load and enable active must still preset
    step(1'b0, 1'b1, 1'b1, 4'd5);
    chk("R1", "reset mod7", q_a, 0);
    chk("R1", "reset off", q_c, 9);
    // R8 two full periods of each sequence under constant enable
    for (int k = 0; k < 30; k++) begin
      int ea, eb, ec;
      ea = (k + 1) % 7; eb = (k + 1) % 10; ec = 9 + (k + 1) % 6;
      step(1'b1, 1'b0, 1'b1, 4'd0);
      chk("R8", "seq mod7", q_a, ea);
      chk("R8", "seq bcd",  q_b, eb);
      chk("R8", "seq off",  q_c, ec);
    end
    // R2 R3 R4 R5 R7 sweep every load value, mix enable and hold
    for (int d = 0; d < 16; d++) begin
      step(1'b1, 1'b1, d[0], 4'(d));
      for (int k = 0; k < 20; k++)
        step(1'b1, 1'b0, (k % 5) != 3, 4'd0);
    end
    // R5 held at end value does not reload
    step(1'b1, 1'b1, 1'b0, 4'd6);
    step(1'b1, 1'b1, 1'b0, 4'd14);
    step(1'b1, 1'b0, 1'b0, 4'd0);
    step(1'b1, 1'b0, 1'b0, 4'd0);
    chk("R5", "held end off", q_c, 14);
    // R2 load wins at end value with enable high
    step(1'b1, 1'b1, 1'b1, 4'd3);
    chk("R2", "load over wrap", q_c, 3);
    // R1 reset mid-run
    step(1'b0, 1'b0, 1'b1, 4'd0);
    chk("R1", "reset bcd", q_b, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule